// File: doc/BRIEF.md
# DMA Register Write Sequencer

This block sits behind a single CPU write port that a DMA controller exposes for all of its configuration. Software writes a stream of bytes to that port. The sequencer decides for each byte whether it opens a new register group or fills a sub-register that an earlier byte asked for, and it keeps every decoded field in a flop ready for the transfer engine.

A byte that opens a group is a base byte. Flag bits inside the base byte say which follow-on bytes come next. The sequencer holds those requests in a pending queue and consumes them in a fixed order, skipping any whose flag was clear. One follow-on byte, the port B timing byte, can itself ask for one more byte that carries the prescaler. Command bytes raise one-cycle strobes for the engine. The engine and the readback path are not part of this block.

Top module: `dma_cfg_sequencer`

## Requirements
- R1: After synchronous reset, every decoded field reads zero, except read_mask, which reads 0x7F. No strobe is high. The first byte written after reset is decoded as a base byte.
- R2: A base byte with bit 7 = 0 and bits 1:0 != 00 opens the transfer group. Its bit 2 is copied to dir_a_to_b, where 1 means A to B and 0 means B to A.
- R3: In a transfer-group base byte, flags on bits 3, 4, 5 and 6 request these follow-on bytes, taken in that order: a_start[7:0], a_start[15:8], blk_len[7:0] and blk_len[15:8]. A byte whose flag is clear is skipped. For example, base byte 0x4D takes a_start[7:0] and then blk_len[15:8].
- R4: A base byte with bit 7 = 0 and bits 2:0 = 100 opens the port A group, and one with bits 2:0 = 000 opens the port B group. In either group, bit 3 goes to the port's is_io output and bits 5:4 go to the port's step output (00 decrement, 01 increment, 1x fixed).
- R5: In the port A and port B base bytes, bit 6 requests a timing byte, whose bits 1:0 go to that port's cycle output. In the port B timing byte, bit 5 requests one further byte, which is stored whole in prescale.
- R6: A base byte with bit 7 = 1 and bits 1:0 = 00 copies its bit 6 into run_enable. The enable command sets run_enable to 1, and the disable command clears it.
- R7: A base byte with bit 7 = 1 and bits 1:0 = 01 copies its bits 6:5 into op_mode (01 continuous, 10 burst). Its bit 2 requests b_start[7:0] and its bit 3 requests b_start[15:8], taken in that order.
- R8: A base byte matching 10xx_x010 copies its bit 5 into auto_restart and its bit 4 into ce_wait_mode. Any other base byte with bits 1:0 = 10 changes no output and opens no follow-on byte.
- R9: Command bytes (bit 7 = 1, bits 1:0 = 11) act as follows. 0xCF raises stb_load, 0xD3 raises stb_continue, 0x87 raises stb_enable and 0x83 raises stb_disable, each for exactly the one cycle after the write. 0xBB requests one follow-on byte, which is stored in read_mask. Every other command value changes no output.
- R10: While any follow-on byte is pending, the next written byte is stored as data for the earliest pending sub-register and is never decoded as a base byte or a command.
- R11: A synchronous reset while follow-on bytes are pending discards them, so the next byte written is decoded as a base byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | A byte is written this cycle |
| wr_data | input | 8 | Written byte |
| dir_a_to_b | output | 1 | Transfer direction, 1 = A to B |
| a_start | output | 16 | Port A start address |
| blk_len | output | 16 | Block length |
| a_is_io | output | 1 | Port A is I/O (1) or memory (0) |
| a_step | output | 2 | Port A address step code |
| a_cycle | output | 2 | Port A cycle length code |
| b_is_io | output | 1 | Port B is I/O (1) or memory (0) |
| b_step | output | 2 | Port B address step code |
| b_cycle | output | 2 | Port B cycle length code |
| prescale | output | 8 | Fixed-time transfer prescaler |
| b_start | output | 16 | Port B start address |
| run_enable | output | 1 | DMA enable level |
| op_mode | output | 2 | Operating mode code |
| auto_restart | output | 1 | Restart at end of block |
| ce_wait_mode | output | 1 | Multiplexed chip-enable/wait mode |
| read_mask | output | 8 | Readback mask |
| stb_load | output | 1 | Load command strobe |
| stb_continue | output | 1 | Continue command strobe |
| stb_enable | output | 1 | Enable command strobe |
| stb_disable | output | 1 | Disable command strobe |

## Verification
If the pending queue holds a wrong request or loses one, the error shows on the very next written byte. That byte lands in the wrong sub-register, or it is decoded as a base byte when it should have been data, or the other way round. A data byte that happens to equal a command code would then raise a spurious strobe. Because every field is checked after every write of a long random byte stream, a queue misstep is caught within one or two writes. A mis-decoded group shows up as a changed field that should not have moved.

// File: rtl/dma_cfg_pkg.sv
package dma_cfg_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2 * BYTE_W;

    // Sub-register slots; within one group a lower index is consumed first.
    typedef enum logic [3:0] {
        SL_A_LO   = 4'd0,
        SL_A_HI   = 4'd1,
        SL_LEN_LO = 4'd2,
        SL_LEN_HI = 4'd3,
        SL_A_TIM  = 4'd4,
        SL_B_TIM  = 4'd5,
        SL_PRESC  = 4'd6,
        SL_B_LO   = 4'd7,
        SL_B_HI   = 4'd8,
        SL_RMASK  = 4'd9
    } slot_e;

    localparam int NUM_SLOTS = 10;

    typedef enum logic [2:0] {
        GRP_NONE,
        GRP_XFER,
        GRP_PORTA,
        GRP_PORTB,
        GRP_ENABLE,
        GRP_MODE,
        GRP_CTRL,
        GRP_CMD
    } grp_e;

    localparam logic [BYTE_W-1:0] CMD_LOAD  = 8'hCF;
    localparam logic [BYTE_W-1:0] CMD_CONT  = 8'hD3;
    localparam logic [BYTE_W-1:0] CMD_ENA   = 8'h87;
    localparam logic [BYTE_W-1:0] CMD_DIS   = 8'h83;
    localparam logic [BYTE_W-1:0] CMD_RMASK = 8'hBB;

endpackage

// File: rtl/dma_cfg_base_decoder.sv
module dma_cfg_base_decoder
    import dma_cfg_pkg::*;
(
    input  logic [BYTE_W-1:0]    byte_i,
    output grp_e                 grp_o,
    output logic [NUM_SLOTS-1:0] queue_o
);

    always_comb begin
        grp_o   = GRP_NONE;
        queue_o = '0;
        if (!byte_i[7]) begin
            if (byte_i[1:0] != 2'b00) begin
                grp_o              = GRP_XFER;
                queue_o[SL_A_LO]   = byte_i[3];
                queue_o[SL_A_HI]   = byte_i[4];
                queue_o[SL_LEN_LO] = byte_i[5];
                queue_o[SL_LEN_HI] = byte_i[6];
            end else if (byte_i[2]) begin
                grp_o             = GRP_PORTA;
                queue_o[SL_A_TIM] = byte_i[6];
            end else begin
                grp_o             = GRP_PORTB;
                queue_o[SL_B_TIM] = byte_i[6];
            end
        end else begin
            unique case (byte_i[1:0])
                2'b00: grp_o = GRP_ENABLE;
                2'b01: begin
                    grp_o            = GRP_MODE;
                    queue_o[SL_B_LO] = byte_i[2];
                    queue_o[SL_B_HI] = byte_i[3];
                end
                2'b10: begin
                    if (!byte_i[6] && !byte_i[2]) grp_o = GRP_CTRL;
                end
                2'b11: begin
                    grp_o             = GRP_CMD;
                    queue_o[SL_RMASK] = (byte_i == CMD_RMASK);
                end
                default: grp_o = GRP_NONE;
            endcase
        end
    end

endmodule

// File: rtl/dma_cfg_slot_picker.sv
module dma_cfg_slot_picker #(
    parameter int N = 4
) (
    input  logic [N-1:0] pend_i,
    output logic [N-1:0] pick_o
);

    for (genvar i = 0; i < N; i++) begin : g_pick
        if (i == 0) begin : g_first
            assign pick_o[i] = pend_i[i];
        end else begin : g_rest
            assign pick_o[i] = pend_i[i] & ~(|pend_i[i-1:0]);
        end
    end

endmodule

// File: rtl/dma_cfg_sequencer.sv
module dma_cfg_sequencer
    import dma_cfg_pkg::*;
#(
    parameter logic [BYTE_W-1:0] RMASK_INIT = 8'h7F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              dir_a_to_b,
    output logic [ADDR_W-1:0] a_start,
    output logic [ADDR_W-1:0] blk_len,
    output logic              a_is_io,
    output logic [1:0]        a_step,
    output logic [1:0]        a_cycle,
    output logic              b_is_io,
    output logic [1:0]        b_step,
    output logic [1:0]        b_cycle,
    output logic [BYTE_W-1:0] prescale,
    output logic [ADDR_W-1:0] b_start,
    output logic              run_enable,
    output logic [1:0]        op_mode,
    output logic              auto_restart,
    output logic              ce_wait_mode,
    output logic [BYTE_W-1:0] read_mask,
    output logic              stb_load,
    output logic              stb_continue,
    output logic              stb_enable,
    output logic              stb_disable
);

    typedef struct packed {
        logic [NUM_SLOTS-1:0] pend;
        logic                 dir;
        logic [ADDR_W-1:0]    a_start;
        logic [ADDR_W-1:0]    len;
        logic                 a_io;
        logic [1:0]           a_step;
        logic [1:0]           a_cyc;
        logic                 b_io;
        logic [1:0]           b_step;
        logic [1:0]           b_cyc;
        logic [BYTE_W-1:0]    presc;
        logic [ADDR_W-1:0]    b_start;
        logic                 en;
        logic [1:0]           mode;
        logic                 restart;
        logic                 ce_wait;
        logic [BYTE_W-1:0]    rmask;
        logic [3:0]           stb;
    } state_t;

    localparam state_t RESET_STATE = '{rmask: RMASK_INIT, default: '0};
    localparam int STB_LOAD = 3;
    localparam int STB_CONT = 2;
    localparam int STB_ENA  = 1;
    localparam int STB_DIS  = 0;

    state_t s_d, s_q;
    grp_e                 grp;
    logic [NUM_SLOTS-1:0] base_queue;
    logic [NUM_SLOTS-1:0] pick;
    logic [NUM_SLOTS-1:0] pend_vis;

    dma_cfg_base_decoder i_dec (
        .byte_i (wr_data),
        .grp_o  (grp),
        .queue_o(base_queue)
    );

    dma_cfg_slot_picker #(.N(NUM_SLOTS)) i_pick (
        .pend_i(s_q.pend),
        .pick_o(pick)
    );

    always_comb begin
        s_d     = s_q;
        s_d.stb = '0;
        if (wr_en) begin
            if (|s_q.pend) begin
                s_d.pend = s_q.pend & ~pick;
                if (pick[SL_A_LO])   s_d.a_start[BYTE_W-1:0]      = wr_data;
                if (pick[SL_A_HI])   s_d.a_start[ADDR_W-1:BYTE_W] = wr_data;
                if (pick[SL_LEN_LO]) s_d.len[BYTE_W-1:0]          = wr_data;
                if (pick[SL_LEN_HI]) s_d.len[ADDR_W-1:BYTE_W]     = wr_data;
                if (pick[SL_A_TIM])  s_d.a_cyc                    = wr_data[1:0];
                if (pick[SL_B_TIM]) begin
                    s_d.b_cyc          = wr_data[1:0];
                    s_d.pend[SL_PRESC] = wr_data[5];
                end
                if (pick[SL_PRESC])  s_d.presc                    = wr_data;
                if (pick[SL_B_LO])   s_d.b_start[BYTE_W-1:0]      = wr_data;
                if (pick[SL_B_HI])   s_d.b_start[ADDR_W-1:BYTE_W] = wr_data;
                if (pick[SL_RMASK])  s_d.rmask                    = wr_data;
            end else begin
                s_d.pend = base_queue;
                unique case (grp)
                    GRP_XFER:   s_d.dir = wr_data[2];
                    GRP_PORTA: begin
                        s_d.a_io   = wr_data[3];
                        s_d.a_step = wr_data[5:4];
                    end
                    GRP_PORTB: begin
                        s_d.b_io   = wr_data[3];
                        s_d.b_step = wr_data[5:4];
                    end
                    GRP_ENABLE: s_d.en = wr_data[6];
                    GRP_MODE:   s_d.mode = wr_data[6:5];
                    GRP_CTRL: begin
                        s_d.restart = wr_data[5];
                        s_d.ce_wait = wr_data[4];
                    end
                    GRP_CMD: begin
                        unique case (wr_data)
                            CMD_LOAD: s_d.stb[STB_LOAD] = 1'b1;
                            CMD_CONT: s_d.stb[STB_CONT] = 1'b1;
                            CMD_ENA: begin
                                s_d.stb[STB_ENA] = 1'b1;
                                s_d.en           = 1'b1;
                            end
                            CMD_DIS: begin
                                s_d.stb[STB_DIS] = 1'b1;
                                s_d.en           = 1'b0;
                            end
                            default: ;
                        endcase
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= RESET_STATE;
        else     s_q <= s_d;
    end

    assign pend_vis     = s_q.pend;
    assign dir_a_to_b   = s_q.dir;
    assign a_start      = s_q.a_start;
    assign blk_len      = s_q.len;
    assign a_is_io      = s_q.a_io;
    assign a_step       = s_q.a_step;
    assign a_cycle      = s_q.a_cyc;
    assign b_is_io      = s_q.b_io;
    assign b_step       = s_q.b_step;
    assign b_cycle      = s_q.b_cyc;
    assign prescale     = s_q.presc;
    assign b_start      = s_q.b_start;
    assign run_enable   = s_q.en;
    assign op_mode      = s_q.mode;
    assign auto_restart = s_q.restart;
    assign ce_wait_mode = s_q.ce_wait;
    assign read_mask    = s_q.rmask;
    assign stb_load     = s_q.stb[STB_LOAD];
    assign stb_continue = s_q.stb[STB_CONT];
    assign stb_enable   = s_q.stb[STB_ENA];
    assign stb_disable  = s_q.stb[STB_DIS];

endmodule

// File: rtl/dma_cfg_sequencer_chk.sv
module dma_cfg_sequencer_chk
    import dma_cfg_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en,
    input logic [NUM_SLOTS-1:0] pend,
    input logic [ADDR_W-1:0]    a_start,
    input logic [ADDR_W-1:0]    blk_len,
    input logic [ADDR_W-1:0]    b_start,
    input logic [BYTE_W-1:0]    prescale,
    input logic                 run_enable,
    input logic                 stb_load,
    input logic                 stb_continue,
    input logic                 stb_enable,
    input logic                 stb_disable
);

    logic any_stb;
    assign any_stb = stb_load | stb_continue | stb_enable | stb_disable;

    // R9
    stb_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({stb_load, stb_continue, stb_enable, stb_disable}));

    // R9
    stb_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
        any_stb |-> $past(wr_en));

    // R10
    data_no_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (pend != '0)) |=> !any_stb);

    // R3
    idle_fields_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(a_start) && $stable(blk_len) && $stable(b_start) && $stable(prescale)));

    // R6
    enable_level_chk: assert property (@(posedge clk) disable iff (rst)
        stb_enable |-> run_enable);

    // R11
    reset_clears_queue_chk: assert property (@(posedge clk)
        rst |=> (pend == '0));

endmodule

bind dma_cfg_sequencer dma_cfg_sequencer_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .pend        (pend_vis),
    .a_start     (a_start),
    .blk_len     (blk_len),
    .b_start     (b_start),
    .prescale    (prescale),
    .run_enable  (run_enable),
    .stb_load    (stb_load),
    .stb_continue(stb_continue),
    .stb_enable  (stb_enable),
    .stb_disable (stb_disable)
);

// File: tb/test_dma_cfg_sequencer.sv
`timescale 1ns/1ps
module test_dma_cfg_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        dir_a_to_b, a_is_io, b_is_io, run_enable, auto_restart, ce_wait_mode;
    logic [15:0] a_start, blk_len, b_start;
    logic [1:0]  a_step, a_cycle, b_step, b_cycle, op_mode;
    logic [7:0]  prescale, read_mask;
    logic        stb_load, stb_continue, stb_enable, stb_disable;

    always #2 clk = ~clk;

    dma_cfg_sequencer i_dma_cfg_sequencer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .dir_a_to_b(dir_a_to_b), .a_start(a_start), .blk_len(blk_len),
        .a_is_io(a_is_io), .a_step(a_step), .a_cycle(a_cycle),
        .b_is_io(b_is_io), .b_step(b_step), .b_cycle(b_cycle),
        .prescale(prescale), .b_start(b_start), .run_enable(run_enable),
        .op_mode(op_mode), .auto_restart(auto_restart), .ce_wait_mode(ce_wait_mode),
        .read_mask(read_mask), .stb_load(stb_load), .stb_continue(stb_continue),
        .stb_enable(stb_enable), .stb_disable(stb_disable)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // expected model state
    logic        e_dir, e_aio, e_bio, e_en, e_rst_flag, e_cew;
    logic [15:0] e_as, e_len, e_bs;
    logic [1:0]  e_astep, e_acyc, e_bstep, e_bcyc, e_mode;
    logic [7:0]  e_presc, e_rmask;
    logic [3:0]  e_stb;
    int          q[$];

    task automatic model_reset();
        e_dir = 0; e_aio = 0; e_bio = 0; e_en = 0; e_rst_flag = 0; e_cew = 0;
        e_as = 0; e_len = 0; e_bs = 0;
        e_astep = 0; e_acyc = 0; e_bstep = 0; e_bcyc = 0; e_mode = 0;
        e_presc = 0; e_rmask = 8'h7F; e_stb = 0;
        q.delete();
    endtask

    // slot codes: 0 As lo,1 As hi,2 len lo,3 len hi,4 A tim,5 B tim,6 presc,7 Bs lo,8 Bs hi,9 rmask
    task automatic model_wr(input logic [7:0] d);
        e_stb = 0;
        if (q.size() > 0) begin
            int s;
            s = q.pop_front();
            case (s)
                0: e_as[7:0] = d;
                1: e_as[15:8] = d;
                2: e_len[7:0] = d;
                3: e_len[15:8] = d;
                4: e_acyc = d[1:0];
                5: begin e_bcyc = d[1:0]; if (d[5]) q.push_back(6); end
                6: e_presc = d;
                7: e_bs[7:0] = d;
                8: e_bs[15:8] = d;
                default: e_rmask = d;
            endcase
        end else if (!d[7] && d[1:0] != 2'b00) begin
            e_dir = d[2];
            for (int b = 3; b <= 6; b++) if (d[b]) q.push_back(b - 3);
        end else if (!d[7] && d[2]) begin
            e_aio = d[3]; e_astep = d[5:4];
            if (d[6]) q.push_back(4);
        end else if (!d[7]) begin
            e_bio = d[3]; e_bstep = d[5:4];
            if (d[6]) q.push_back(5);
        end else if (d[1:0] == 2'b00) begin
            e_en = d[6];
        end else if (d[1:0] == 2'b01) begin
            e_mode = d[6:5];
            if (d[2]) q.push_back(7);
            if (d[3]) q.push_back(8);
        end else if (d[1:0] == 2'b10) begin
            if (d[6] == 1'b0 && d[2] == 1'b0) begin e_rst_flag = d[5]; e_cew = d[4]; end
        end else begin
            case (d)
                8'hCF: e_stb = 4'b1000;
                8'hD3: e_stb = 4'b0100;
                8'h87: begin e_stb = 4'b0010; e_en = 1; end
                8'h83: begin e_stb = 4'b0001; e_en = 0; end
                8'hBB: q.push_back(9);
                default: ;
            endcase
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2 dir_a_to_b", 32'(dir_a_to_b), 32'(e_dir));
        chk("R3 a_start/blk_len", {a_start, blk_len}, {e_as, e_len});
        chk("R4 port modes", 32'({a_is_io, a_step, b_is_io, b_step}),
            32'({e_aio, e_astep, e_bio, e_bstep}));
        chk("R5 cycles/prescale", 32'({a_cycle, b_cycle, prescale}), 32'({e_acyc, e_bcyc, e_presc}));
        chk("R6 run_enable", 32'(run_enable), 32'(e_en));
        chk("R7 b_start/op_mode", 32'({b_start, op_mode}), 32'({e_bs, e_mode}));
        chk("R8 restart/ce_wait", 32'({auto_restart, ce_wait_mode}), 32'({e_rst_flag, e_cew}));
        chk("R9 strobes/read_mask",
            32'({stb_load, stb_continue, stb_enable, stb_disable, read_mask}),
            32'({e_stb, e_rmask}));
    endtask

    // one write: drive at negedge, captured at posedge, checked at following negedge
    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        model_wr(d);
        @(negedge clk);
        wr_en = 1'b0;
        compare_all();
        e_stb = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset values
        compare_all();
        chk("R1 read_mask reset", 32'(read_mask), 32'h7F);
        wr(8'h05);
        chk("R1 first byte is base", 32'(dir_a_to_b), 32'd1);

        // R3 sparse flags: bits 3 and 6
        wr(8'h4D); wr(8'h12); wr(8'h34);
        chk("R3 sparse a_start", 32'(a_start), 32'h0012);
        chk("R3 sparse blk_len", 32'(blk_len), 32'h3400);
        // R3 all four follow-on bytes
        wr(8'h79); wr(8'hA1); wr(8'hB2); wr(8'hC3); wr(8'hD4);
        chk("R3 full a_start", 32'(a_start), 32'hB2A1);
        chk("R3 full blk_len", 32'(blk_len), 32'hD4C3);
        chk("R2 dir B to A", 32'(dir_a_to_b), 32'd0);

        // R10 command codes taken as data
        wr(8'h19); wr(8'hCF); wr(8'h87);
        chk("R10 data not decoded", 32'({a_start, run_enable}), {16'h87CF, 1'b0});

        // R4/R5 port A and port B with nested prescaler
        wr(8'h54); wr(8'h02);
        chk("R4 port A", 32'({a_is_io, a_step}), 32'({1'b0, 2'b01}));
        chk("R5 port A cycle", 32'(a_cycle), 32'd2);
        wr(8'h68); wr(8'h21); wr(8'hA5);
        chk("R4 port B", 32'({b_is_io, b_step}), 32'({1'b1, 2'b10}));
        chk("R5 prescale", 32'({b_cycle, prescale}), 32'({2'b01, 8'hA5}));
        wr(8'h68); wr(8'h01); wr(8'h07);
        chk("R5 no prescale byte queued", 32'({prescale, dir_a_to_b}), 32'({8'hA5, 1'b1}));

        // R7 port B start and mode
        wr(8'hAD); wr(8'h11); wr(8'h22);
        chk("R7 b_start", 32'({b_start, op_mode}), 32'({16'h2211, 2'b01}));
        wr(8'hC9); wr(8'h5A);
        chk("R7 high byte only", 32'({b_start, op_mode}), 32'({16'h5A11, 2'b10}));

        // R8 control group and ignored bytes
        wr(8'hB2);
        chk("R8 restart/ce_wait set", 32'({auto_restart, ce_wait_mode}), 32'd3);
        wr(8'hC2); wr(8'h86); wr(8'h82);
        chk("R8 ignored then cleared", 32'({auto_restart, ce_wait_mode}), 32'd0);

        // R9 commands
        wr(8'hCF); wr(8'hD3); wr(8'h87);
        chk("R6 enable cmd", 32'(run_enable), 32'd1);
        wr(8'h83);
        chk("R6 disable cmd", 32'(run_enable), 32'd0);
        wr(8'hBB); wr(8'h3C);
        chk("R9 read_mask", 32'(read_mask), 32'h3C);
        wr(8'hFF);
        wr(8'hC0);
        chk("R6 group enable", 32'(run_enable), 32'd1);
        wr(8'h80);
        chk("R6 group disable", 32'(run_enable), 32'd0);

        // R11 reset mid-sequence
        wr(8'h79); wr(8'h44);
        do_reset();
        compare_all();
        wr(8'h05);
        chk("R11 base after reset", 32'({dir_a_to_b, a_start}), 32'({1'b1, 16'h0000}));

        // random byte stream against the model
        seed = 32'h1234_5678;
        void'($urandom(seed));
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] d;
            d = 8'($urandom());
            if (i % 97 == 0) d = 8'hBB;
            wr(d);
            if (i % 701 == 700) begin
                do_reset();
                compare_all();
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule